// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block gathers the per-pin pending flags of a large GPIO array into a compact summary vector and raises one shared interrupt line towards the processor. Pins are taken in groups of four consecutive pins, and each group drives one summary bit that is the OR of its four flags. With the default 184 pins there are 46 summary bits. Per-pin detection and per-pin status clearing happen in the pin logic outside this block. The block only reduces, registers and reports the flags.

Software reads the summary through a small word-wide register port and finds which groups need service. It then services the pins and finally writes an end-of-interrupt (EOI) command. The shared line needs no separate acknowledge before servicing starts. Once raised, the line stays high until EOI. EOI drops it for one cycle, and it comes back at once if any group is still pending. This way a pin that became pending during servicing is not lost.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit k is registered one clock after the pins and equals the OR of pin_pend[4k], pin_pend[4k+1], pin_pend[4k+2] and pin_pend[4k+3].
- R2: A read of address 0 returns summary bits 0 to 31 in data bits 0 to 31. Read data appears on reg_rdata one clock after the address is presented.
- R3: A read of address 1 returns summary bits 32 to 45 in data bits 0 to 13. Data bits 14 to 31 always read 0.
- R4: Address 3 always reads 0.
- R5: While irq_out is low and a wake-up is allowed, irq_out rises one clock after any summary bit is set, which is two clocks after the pin flag.
- R6: Once high, irq_out stays high until an EOI write, even when every pin flag has cleared.
- R7: An EOI write is a write to address 2 with data bit 0 set. If irq_out is high, it goes low for exactly one cycle on the next clock. On the clock after that, it goes high again if any summary bit is set, and otherwise it stays low.
- R8: The EOI bit clears itself. A read of address 2 returns 0 at all times.
- R9: Writes to addresses 0 and 1 are ignored, and the summary read afterwards still follows the pins.
- R10: A write to address 2 with data bit 0 clear has no effect on irq_out.
- R11: A synchronous active-high reset clears the summary, irq_out and reg_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_pend | input | 184 | Pending flag of each pin |
| reg_addr | input | 2 | Word address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Shared interrupt line to the processor |

## Verification
The hardest case to reach is the re-arm path. The line has to be high and a group has to stay pending at the moment EOI lands, so that the single low cycle followed by a reassertion can be seen. The stimulus holds one pin pending across the EOI write and samples irq_out on each of the next two clocks. It also repeats the EOI after the pins have cleared and checks that the line then stays low. A sweep walks a single pending flag across every pin and reads both summary words for each one. It then drives several arithmetic multi-pin patterns whose expected words are recomputed group by group.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    ADDR_SUM_LO = 2'd0,
    ADDR_SUM_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  localparam int EOI_BIT = 0;
endpackage

// File: rtl/gpio_grp_or.sv
module gpio_grp_or #(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_pend,
  output logic [NUM_GRP-1:0]  sum_q
);
  logic [NUM_GRP-1:0] sum_d;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign sum_d[g] = |pin_pend[g*GRP_SIZE +: GRP_SIZE];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/gpio_irq_arm.sv
module gpio_irq_arm (
  input  logic clk,
  input  logic rst,
  input  logic any_pend,
  input  logic eoi,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (irq_q) irq_q <= ~eoi;
    else            irq_q <= any_pend;
  end
endmodule

// File: rtl/gpio_sum_regs.sv
module gpio_sum_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GRP = 46,
  parameter int WORD_W  = 32,
  localparam int PAD_W  = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_GRP-1:0] sum_q,
  output logic [WORD_W-1:0]  rdata_q
);
  logic [PAD_W-1:0]  sum_pad;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GRP-1:0] = sum_q;
    case (reg_addr)
      ADDR_SUM_LO: rdata_d = sum_pad[WORD_W-1:0];
      ADDR_SUM_HI: rdata_d = sum_pad[PAD_W-1:WORD_W];
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  parameter int WORD_W   = 32,
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_out
);
  logic [NUM_GRP-1:0] sum_q;
  logic               eoi;

  assign eoi = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[EOI_BIT];

  gpio_grp_or #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) grp_i (
    .clk(clk), .rst(rst), .pin_pend(pin_pend), .sum_q(sum_q)
  );

  gpio_irq_arm arm_i (
    .clk(clk), .rst(rst), .any_pend(|sum_q), .eoi(eoi), .irq_q(irq_out)
  );

  gpio_sum_regs #(.NUM_GRP(NUM_GRP), .WORD_W(WORD_W)) regs_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .sum_q(sum_q), .rdata_q(reg_rdata)
  );
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  parameter int WORD_W   = 32,
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE,
  localparam int HI_BITS = NUM_GRP - WORD_W
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pin_pend,
  input logic [1:0]          reg_addr,
  input logic                reg_wr,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic [WORD_W-1:0]   reg_rdata,
  input logic                irq_out,
  input logic [NUM_GRP-1:0]  sum_q
);
  logic eoi_wr;
  assign eoi_wr = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      assert_grp_or_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_q[g] == $past(|pin_pend[g*GRP_SIZE +: GRP_SIZE])));
    end
  endgenerate

  assert_hi_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd1) |=> (reg_rdata[WORD_W-1:HI_BITS] == '0));

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd3) |=> (reg_rdata == '0));

  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|sum_q));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !eoi_wr) |=> irq_out);

  assert_eoi_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_out && eoi_wr) |=> !irq_out);

  assert_eoi_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd2) |=> (reg_rdata == '0));

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (!irq_out && reg_rdata == '0));
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
  .NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst(rst), .pin_pend(pin_pend), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .sum_q(sum_q)
);

// File: tb/gpio_irq_summary_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_summary_tb_top;
  localparam int NP = 184;
  localparam int G  = 4;
  localparam int NG = NP / G;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_pend;
  logic [1:0]    reg_addr;
  logic          reg_wr;
  logic [W-1:0]  reg_wdata;
  logic [W-1:0]  reg_rdata;
  logic          irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpio_irq_summary dut_i (
    .clk(clk), .rst(rst), .pin_pend(pin_pend), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] expect_sum(input logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int k = 0; k < NG; k++)
      for (int j = 0; j < G; j++)
        if (p[k*G+j]) s[k] = 1'b1;
    return s;
  endfunction

  task automatic set_pins(input logic [NP-1:0] p);
    @(negedge clk); pin_pend = p;
    tick();
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0;
    tick();
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    tick();
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic check_words(input string req, input logic [NP-1:0] p);
    logic [63:0] e;
    logic [W-1:0] d;
    e = expect_sum(p);
    rd(2'd0, d); check({req, " R2 low word"}, d, e[31:0]);
    rd(2'd1, d); check({req, " R3 high word"}, d, e[63:32]);
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [NP-1:0] p;
    rst = 1'b1; pin_pend = '1; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) tick();
    check("R11 irq at reset", {31'd0, irq_out}, 32'd0);
    check("R11 rdata at reset", reg_rdata, 32'd0);
    @(negedge clk); rst = 1'b0; pin_pend = '0;
    tick(); tick();
    rd(2'd0, d); check("R11 summary cleared", d, 32'd0);
    check("R11 irq idle", {31'd0, irq_out}, 32'd0);

    // R1 walk a single pending flag across every pin
    for (int i = 0; i < NP; i++) begin
      p = '0; p[i] = 1'b1;
      set_pins(p);
      check_words("R1 single pin", p);
    end

    // R1 multi-pin arithmetic patterns
    for (int s = 0; s < 5; s++) begin
      p = '0;
      for (int j = 0; j < NP; j++) p[j] = ((j * 7 + s) % 5) == 0;
      set_pins(p);
      check_words("R1 pattern", p);
    end

    // R3 / R4 upper bits and reserved address with everything pending
    set_pins('1);
    rd(2'd1, d); check("R3 high bits zero", d, 32'h0000_3fff);
    rd(2'd3, d); check("R4 reserved reads zero", d, 32'd0);

    // R9 writes to summary ignored
    p = '0; p[9] = 1'b1; p[150] = 1'b1;
    set_pins(p);
    wr(2'd0, 32'hffff_ffff);
    wr(2'd1, 32'hffff_ffff);
    check_words("R9 after write", p);
    wr(2'd0, 32'h0);
    check_words("R9 after zero write", p);

    // clear line to a known idle state
    set_pins('0);
    wr(2'd2, 32'h1);
    tick(); tick();
    check("R7 idle after eoi", {31'd0, irq_out}, 32'd0);

    // R5 rise latency
    p = '0; p[21] = 1'b1;
    @(negedge clk); pin_pend = p;
    tick();
    check("R5 not yet", {31'd0, irq_out}, 32'd0);
    tick();
    check("R5 asserted", {31'd0, irq_out}, 32'd1);

    // R6 hold after pins clear
    @(negedge clk); pin_pend = '0;
    repeat (4) tick();
    check("R6 hold", {31'd0, irq_out}, 32'd1);

    // R10 write ctrl with bit 0 clear
    wr(2'd2, 32'hffff_fffe);
    tick();
    check("R10 no effect", {31'd0, irq_out}, 32'd1);

    // R7 EOI with nothing pending: stays low
    @(negedge clk); reg_addr = 2'd2; reg_wr = 1'b1; reg_wdata = 32'h1;
    tick();
    check("R7 drop", {31'd0, irq_out}, 32'd0);
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    tick();
    check("R7 stays low", {31'd0, irq_out}, 32'd0);
    tick();
    check("R7 stays low later", {31'd0, irq_out}, 32'd0);

    // R7 EOI with pending: one low cycle then reassert
    p = '0; p[183] = 1'b1;
    set_pins(p);
    tick();
    check("R5 reassert high", {31'd0, irq_out}, 32'd1);
    @(negedge clk); reg_addr = 2'd2; reg_wr = 1'b1; reg_wdata = 32'h1;
    tick();
    check("R7 single low cycle", {31'd0, irq_out}, 32'd0);
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    tick();
    check("R7 reasserted", {31'd0, irq_out}, 32'd1);

    // R8 EOI reads back zero
    rd(2'd2, d); check("R8 ctrl reads zero", d, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule